// File: doc/BRIEF.md
# Pipeline hazard detection unit

This block decides, every cycle, how an in-order five-stage pipeline (fetch, decode, execute, memory, writeback) copes with dependencies between neighbouring instructions. It looks at the register numbers that each stage reads or writes, together with the write-enable, load and branch flags. From these it produces bypass selects for the two execute-stage ALU operands. It also produces bypass selects for the two operands of the branch comparator, which sits in decode. Finally it raises a single stall condition that freezes fetch and decode and clears the execute pipeline register.

The unit is purely combinational. It holds no state, and it has no clock or reset of its own. The surrounding datapath owns the muxes, the register file and the pipeline registers. It wires the stage fields in and the selects out.

Top module: `hazard_unit`

## Requirements
- R1: An execute-stage operand select (fwd_a_e for rs_e, fwd_b_e for rt_e) equals 2'b10 when its source register is nonzero, equals dst_m, and wen_m is high.
- R2: When R1 does not apply, the select equals 2'b01 if the source register is nonzero, equals dst_w, and wen_w is high. Otherwise it equals 2'b00, which means the register file value is used. The code 2'b11 never appears.
- R3: fwd_b_e follows the same rules using rt_e. When the memory and writeback stages both write the source register, the memory result (2'b10) wins.
- R4: Register 0 is never a bypass source. A zero source register gives select 2'b00 in execute and 0 in decode, whatever the writers are.
- R5: A load-use stall occurs when ld_e is high and rt_e equals rs_d or rt_d.
- R6: fwd_a_d (for rs_d) and fwd_b_d (for rt_d) are high exactly when that register is nonzero, equals dst_m, and wen_m is high.
- R7: A branch stall occurs when branch_d and wen_e are high and dst_e equals rs_d or rt_d.
- R8: A branch stall also occurs when branch_d and ld_m are high and dst_m equals rs_d or rt_d.
- R9: stall_f, stall_d and flush_e all equal the OR of the load-use stall and the branch stall.
- R10: When no condition above holds, all selects are zero and stall_f, stall_d and flush_e are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rs_d | input | REG_W | First source register in decode |
| rt_d | input | REG_W | Second source register in decode |
| branch_d | input | 1 | Decode holds a branch |
| rs_e | input | REG_W | First source register in execute |
| rt_e | input | REG_W | Second source register in execute (load target) |
| dst_e | input | REG_W | Destination register in execute |
| wen_e | input | 1 | Execute instruction writes a register |
| ld_e | input | 1 | Execute instruction is a load |
| dst_m | input | REG_W | Destination register in memory |
| wen_m | input | 1 | Memory instruction writes a register |
| ld_m | input | 1 | Memory instruction is a load |
| dst_w | input | REG_W | Destination register in writeback |
| wen_w | input | 1 | Writeback instruction writes a register |
| fwd_a_e | output | 2 | Execute operand A source: 00 file, 01 writeback, 10 memory |
| fwd_b_e | output | 2 | Execute operand B source, same coding |
| fwd_a_d | output | 1 | Branch operand A taken from memory stage |
| fwd_b_d | output | 1 | Branch operand B taken from memory stage |
| stall_f | output | 1 | Hold the fetch stage |
| stall_d | output | 1 | Hold the decode stage |
| flush_e | output | 1 | Clear the execute pipeline register |

## Verification
The bench builds the unit with REG_W = 2, so there are only four register numbers. At that width all seven register fields and all six flags can be swept together, which is 2^20 patterns. Every way registers can alias across stages is therefore covered, including register 0 as a source or as a destination and both late stages writing the same register. Directed patterns then cover a load in execute feeding a branch, and memory-over-writeback priority.

// File: rtl/hz_pkg.sv
package hz_pkg;
  typedef enum logic [1:0] {
    SRC_RF  = 2'b00,
    SRC_WB  = 2'b01,
    SRC_MEM = 2'b10
  } fwd_src_e;
endpackage

// File: rtl/hz_exec_fwd.sv
module hz_exec_fwd
  import hz_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] src,
  input  logic [REG_W-1:0] dst_m,
  input  logic             wen_m,
  input  logic [REG_W-1:0] dst_w,
  input  logic             wen_w,
  output fwd_src_e         sel
);
  logic live;
  logic hit_m;
  logic hit_w;

  assign live  = (src != '0);
  assign hit_m = live && wen_m && (src == dst_m);
  assign hit_w = live && wen_w && (src == dst_w);

  // memory stage holds the younger result, so it takes priority (R3)
  always_comb begin
    if (hit_m)      sel = SRC_MEM;
    else if (hit_w) sel = SRC_WB;
    else            sel = SRC_RF;
  end
endmodule

// File: rtl/hz_dec_fwd.sv
module hz_dec_fwd #(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] src,
  input  logic [REG_W-1:0] dst_m,
  input  logic             wen_m,
  output logic             hit
);
  assign hit = (src != '0) && wen_m && (src == dst_m);
endmodule

// File: rtl/hz_stall.sv
module hz_stall #(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] rs_d,
  input  logic [REG_W-1:0] rt_d,
  input  logic             branch_d,
  input  logic [REG_W-1:0] rt_e,
  input  logic [REG_W-1:0] dst_e,
  input  logic             wen_e,
  input  logic             ld_e,
  input  logic [REG_W-1:0] dst_m,
  input  logic             ld_m,
  output logic             load_use,
  output logic             br_hold,
  output logic             hold
);
  logic use_e_ld;
  logic use_e_wr;
  logic use_m_ld;

  assign use_e_ld = (rt_e == rs_d) || (rt_e == rt_d);
  assign use_e_wr = (dst_e == rs_d) || (dst_e == rt_d);
  assign use_m_ld = (dst_m == rs_d) || (dst_m == rt_d);

  assign load_use = ld_e && use_e_ld;
  assign br_hold  = branch_d && ((wen_e && use_e_wr) || (ld_m && use_m_ld));
  assign hold     = load_use || br_hold;
endmodule

// File: rtl/hazard_unit.sv
module hazard_unit
  import hz_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] rs_d,
  input  logic [REG_W-1:0] rt_d,
  input  logic             branch_d,
  input  logic [REG_W-1:0] rs_e,
  input  logic [REG_W-1:0] rt_e,
  input  logic [REG_W-1:0] dst_e,
  input  logic             wen_e,
  input  logic             ld_e,
  input  logic [REG_W-1:0] dst_m,
  input  logic             wen_m,
  input  logic             ld_m,
  input  logic [REG_W-1:0] dst_w,
  input  logic             wen_w,
  output logic [1:0]       fwd_a_e,
  output logic [1:0]       fwd_b_e,
  output logic             fwd_a_d,
  output logic             fwd_b_d,
  output logic             stall_f,
  output logic             stall_d,
  output logic             flush_e
);
  localparam int N_OPS = 2;

  logic [REG_W-1:0] src_e [N_OPS];
  logic [REG_W-1:0] src_d [N_OPS];
  fwd_src_e         sel_e [N_OPS];
  logic             hit_d [N_OPS];
  logic             load_use;
  logic             br_hold;
  logic             hold;

  assign src_e[0] = rs_e;
  assign src_e[1] = rt_e;
  assign src_d[0] = rs_d;
  assign src_d[1] = rt_d;

  for (genvar gi = 0; gi < N_OPS; gi++) begin : g_op
    hz_exec_fwd #(.REG_W(REG_W)) u_xf (
      .src   (src_e[gi]),
      .dst_m (dst_m),
      .wen_m (wen_m),
      .dst_w (dst_w),
      .wen_w (wen_w),
      .sel   (sel_e[gi])
    );
    hz_dec_fwd #(.REG_W(REG_W)) u_df (
      .src   (src_d[gi]),
      .dst_m (dst_m),
      .wen_m (wen_m),
      .hit   (hit_d[gi])
    );
  end

  hz_stall #(.REG_W(REG_W)) u_st (
    .rs_d     (rs_d),
    .rt_d     (rt_d),
    .branch_d (branch_d),
    .rt_e     (rt_e),
    .dst_e    (dst_e),
    .wen_e    (wen_e),
    .ld_e     (ld_e),
    .dst_m    (dst_m),
    .ld_m     (ld_m),
    .load_use (load_use),
    .br_hold  (br_hold),
    .hold     (hold)
  );

  assign fwd_a_e = sel_e[0];
  assign fwd_b_e = sel_e[1];
  assign fwd_a_d = hit_d[0];
  assign fwd_b_d = hit_d[1];
  assign stall_f = hold;
  assign stall_d = hold;
  assign flush_e = hold;

  // cross-unit checks, skipped while any input is still unknown
  always_comb begin
    if (!$isunknown({rs_d, rt_d, branch_d, rs_e, rt_e, dst_e, wen_e, ld_e,
                     dst_m, wen_m, ld_m, dst_w, wen_w})) begin
      p_sel_legal_r2: assert (fwd_a_e != 2'b11 && fwd_b_e != 2'b11)
        else $error("illegal execute select code");
      p_zero_src_r4: assert ((rs_e != '0 || fwd_a_e == SRC_RF) &&
                             (rt_e != '0 || fwd_b_e == SRC_RF) &&
                             (rs_d != '0 || !fwd_a_d) &&
                             (rt_d != '0 || !fwd_b_d))
        else $error("register 0 bypassed");
      p_dec_needs_wen_r6: assert (!(fwd_a_d || fwd_b_d) || wen_m)
        else $error("decode bypass without memory writer");
      p_hold_tied_r9: assert (stall_f == stall_d && stall_d == flush_e)
        else $error("stall outputs disagree");
      p_quiet_r10: assert (branch_d || ld_e || !stall_f)
        else $error("stall without load or branch");
      p_mem_wins_r3: assert (!(wen_m && rs_e != '0 && rs_e == dst_m) ||
                             fwd_a_e == SRC_MEM)
        else $error("memory result lost priority");
    end
  end
endmodule

// File: tb/sim_hazard_unit.sv
module sim_hazard_unit;
  localparam int W = 2;

  logic clk = 1'b0;
  always #10 clk = ~clk; // 50 MHz

  logic [W-1:0] rs_d = '0, rt_d = '0, rs_e = '0, rt_e = '0;
  logic [W-1:0] dst_e = '0, dst_m = '0, dst_w = '0;
  logic branch_d = 0, wen_e = 0, ld_e = 0, wen_m = 0, ld_m = 0, wen_w = 0;
  logic [1:0] fwd_a_e, fwd_b_e;
  logic fwd_a_d, fwd_b_d, stall_f, stall_d, flush_e;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  hazard_unit #(.REG_W(W)) u0 (
    .rs_d(rs_d), .rt_d(rt_d), .branch_d(branch_d),
    .rs_e(rs_e), .rt_e(rt_e), .dst_e(dst_e), .wen_e(wen_e), .ld_e(ld_e),
    .dst_m(dst_m), .wen_m(wen_m), .ld_m(ld_m),
    .dst_w(dst_w), .wen_w(wen_w),
    .fwd_a_e(fwd_a_e), .fwd_b_e(fwd_b_e), .fwd_a_d(fwd_a_d), .fwd_b_d(fwd_b_d),
    .stall_f(stall_f), .stall_d(stall_d), .flush_e(flush_e)
  );

  function automatic logic [1:0] want_sel(logic [W-1:0] s);
    if (s == 0) return 2'b00;                       // R4
    if (wen_m && s == dst_m) return 2'b10;          // R1, R3
    if (wen_w && s == dst_w) return 2'b01;          // R2
    return 2'b00;
  endfunction

  function automatic logic want_hold();
    logic lu, b1, b2;
    lu = ld_e && (rs_d == rt_e || rt_d == rt_e);                    // R5
    b1 = branch_d && wen_e && (rs_d == dst_e || rt_d == dst_e);     // R7
    b2 = branch_d && ld_m && (rs_d == dst_m || rt_d == dst_m);      // R8
    return lu | b1 | b2;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_all(string ctx);
    logic h;
    h = want_hold();
    chk({ctx, " R1/R2 fwd_a_e"}, fwd_a_e, want_sel(rs_e));
    chk({ctx, " R3 fwd_b_e"}, fwd_b_e, want_sel(rt_e));
    chk({ctx, " R6 fwd_d"}, {fwd_a_d, fwd_b_d},
        {want_sel(rs_d) == 2'b10 && rs_d != 0, want_sel(rt_d) == 2'b10 && rt_d != 0});
    chk({ctx, " R9 stall"}, {stall_f, stall_d, flush_e}, {h, h, h});
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #5;
    // R10: all-quiet pattern
    chk("R10 sel", {fwd_a_e, fwd_b_e, fwd_a_d, fwd_b_d}, 0);
    chk("R10 stall", {stall_f, stall_d, flush_e}, 0);

    // R3: memory and writeback both write r1, execute reads r1 on both ports
    rs_e = 1; rt_e = 1; dst_m = 1; dst_w = 1; wen_m = 1; wen_w = 1;
    #1 chk("R3 priority a", fwd_a_e, 2); chk("R3 priority b", fwd_b_e, 2);
    chk("R3 no stall", stall_f, 0);

    // R4: writers target r0, sources r0
    rs_e = 0; rt_e = 0; dst_m = 0; dst_w = 0; rs_d = 0; rt_d = 0;
    #1 chk("R4 zero", {fwd_a_e, fwd_b_e, fwd_a_d, fwd_b_d}, 0);

    // R5: load in execute feeds a branch in decode
    wen_m = 0; wen_w = 0;
    ld_e = 1; wen_e = 1; rt_e = 2; dst_e = 2; rs_d = 2; rt_d = 3; branch_d = 1;
    #1 chk("R5/R7 load feeds branch", {stall_f, stall_d, flush_e}, 3'b111);

    // R8: load in memory feeds branch
    ld_e = 0; wen_e = 0; ld_m = 1; dst_m = 3;
    #1 chk("R8 mem load feeds branch", stall_d, 1);
    branch_d = 0;
    #1 chk("R8 no branch no stall", stall_d, 0);
    ld_m = 0;

    // exhaustive sweep of all 2^20 patterns
    for (int v = 0; v < (1 << 20); v++) begin
      rs_d = v[1:0];   rt_d = v[3:2];   rs_e = v[5:4];  rt_e = v[7:6];
      dst_e = v[9:8];  dst_m = v[11:10]; dst_w = v[13:12];
      branch_d = v[14]; wen_e = v[15]; ld_e = v[16];
      wen_m = v[17]; ld_m = v[18]; wen_w = v[19];
      #1 check_all("sweep");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule